// File: doc/BRIEF.md
# Alarm RTC with shadow-register sync

This block is a memory-mapped real-time clock with a 32-bit register port. Software writes land in shadow copies; a serial copy sequencer moves them one at a time into the counting state, which advances on a slow-clock strobe (`slow_tick_i`, one core-clock pulse per slow-clock period). Each shadowed register owns a stale flag in the status register. The flag is raised by the write and dropped once the sequencer has copied that register, so software can poll for completion before trusting a read or an alarm.

The block holds a running seconds counter, an alarm compare value, a millisecond-paced watchdog and six persistent words. Two of these words matter to the block: one holds the alarm enables and the wake flag, the other holds the watchdog arm bit. The control register and all persistent words accept plain, set-bits and clear-bits writes. Register pages are 16 bytes apart: address bits 7:4 pick the register and bits 3:2 pick the write kind (0 plain, 1 set bits, 2 clear bits). Reads return the register whatever the write-kind bits are.

Top module: `rtc_shadow`

## Requirements
- R1: After reset the control word (0x00) reads 0, status (0x10) reads 0x8000_0000 (bit 31 present, no stale flags), seconds (0x30) reads 0, and all three outputs are low.
- R2: For the control word and persistent words (0x60 + 0x10*k, k = 0..5), offset +0 replaces the value, +4 ORs the written bits in and +8 clears them; control bits are 0 alarm irq enable, 1 ms irq enable, 4 watchdog enable.
- R3: A write to a shadowed register sets its stale flag at status bit 16+i in the next cycle: i = k for persistent word k, 6 for alarm (0x40), 7 for seconds (0x30).
- R4: Stale flags are cleared by the sequencer one per copy, lowest index first (persistent 0..5, alarm, seconds), and eight back-to-back writes are all copied within 12 slow ticks (3 ms at the default of 4 ticks per ms).
- R5: Seconds reads the live count; once copied it equals the written value and then rises by one every TICKS_PER_SEC slow ticks; a copy in the same cycle as a tick wins.
- R6: Control bit 2 (alarm pending) sets while persistent 0 bit 2 is set and live seconds equals live alarm; `alarm_irq_o` is high exactly when bit 2 and control bit 0 are both set.
- R7: Alarm pending ignores plain and set-bits writes and is cleared only by a clear-bits write with bit 2; a match in the same cycle as that clear keeps it set.
- R8: Persistent 0 bit 7 (wake flag) sets on an alarm match while persistent 0 bit 1 is set, and is cleared by a clear-bits write to persistent 0 with bit 7.
- R9: `ms_irq_o` is high for one core cycle on every TICKS_PER_MS-th slow tick while control bit 1 is set, and stays low otherwise.
- R10: The watchdog (0x50) counts down once per ms tick while control bit 4 and live persistent 1 bit 31 are set; reaching zero gives a one-cycle `wdog_rst_o` pulse; a value of 0 never pulses, and a disabled watchdog holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock period |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt, level |
| ms_irq_o | output | 1 | Millisecond interrupt pulse |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The alarm match and a software clear of the pending flag can land in the same cycle; the bench provokes this by issuing the clear-bits write while live seconds still equals the alarm, and judges it by the pending bit and `alarm_irq_o` staying set. Only after the alarm enable has been removed through the persistent word and copied does the same clear take effect. A second overlap, a write to a register whose copy is completing, is covered by writing the eight shadowed registers back to back while copies run, and by requiring the stale pattern to drain strictly from the low end.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_PST   = 6;
  localparam int NUM_SLOT  = NUM_PST + 2;
  localparam int SLOT_ALRM = NUM_PST;
  localparam int SLOT_SECS = NUM_PST + 1;

  localparam logic [3:0] PG_CTRL = 4'h0;
  localparam logic [3:0] PG_STAT = 4'h1;
  localparam logic [3:0] PG_SECS = 4'h3;
  localparam logic [3:0] PG_ALRM = 4'h4;
  localparam logic [3:0] PG_WDOG = 4'h5;
  localparam logic [3:0] PG_PST0 = 4'h6;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } wr_op_e;

  localparam int CB_ALRM_IE  = 0;
  localparam int CB_MS_IE    = 1;
  localparam int CB_PEND     = 2;
  localparam int CB_WDOG_EN  = 4;
  localparam int PB_WAKE_EN  = 1;
  localparam int PB_ALRM_EN  = 2;
  localparam int PB_WAKE_FLG = 7;
  localparam int PB_WDOG_ARM = 31;

  function automatic logic [31:0] merge_write(logic [31:0] old, logic [31:0] d, wr_op_e op);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return old | d;
      OP_CLEAR: return old & ~d;
      default:  return old;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32,
  parameter int TICKS_PER_MS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tick_i,
  output logic sec_tick_o,
  output logic ms_tick_o
);
  localparam int SCW = $clog2(TICKS_PER_SEC + 1);
  localparam int MCW = $clog2(TICKS_PER_MS + 1);

  logic [SCW-1:0] sec_q;
  logic [MCW-1:0] ms_q;

  assign sec_tick_o = slow_tick_i && (sec_q == SCW'(TICKS_PER_SEC - 1));
  assign ms_tick_o  = slow_tick_i && (ms_q == MCW'(TICKS_PER_MS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ms_q  <= '0;
    end else if (slow_tick_i) begin
      sec_q <= sec_tick_o ? '0 : sec_q + 1'b1;
      ms_q  <= ms_tick_o ? '0 : ms_q + 1'b1;
    end
  end

  // R9: prescaler stays inside its period
  a_r9_ms_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= MCW'(TICKS_PER_MS - 1));
  a_r5_sec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q <= SCW'(TICKS_PER_SEC - 1));
endmodule

// File: rtl/rtc_copy_seq.sv
module rtc_copy_seq #(
  parameter int NUM_SLOT   = 8,
  parameter int COPY_TICKS = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        slow_tick_i,
  input  logic [NUM_SLOT-1:0]         stale_i,
  output logic                        copy_o,
  output logic [$clog2(NUM_SLOT)-1:0] slot_o
);
  localparam int SW = $clog2(NUM_SLOT);
  localparam int CW = $clog2(COPY_TICKS + 1);

  logic          busy_q;
  logic [SW-1:0] slot_q, pick;
  logic [CW-1:0] cnt_q;

  // lowest stale index goes first
  always_comb begin
    pick = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--)
      if (stale_i[i]) pick = SW'(i);
  end

  assign copy_o = busy_q && slow_tick_i && (cnt_q == CW'(COPY_TICKS - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (|stale_i) begin
        busy_q <= 1'b1;
        slot_q <= pick;
        cnt_q  <= '0;
      end
    end else if (slow_tick_i) begin
      if (copy_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R4: a copy always targets a register that is still stale
  a_r4_copy_hits_stale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_o |-> stale_i[slot_o]);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ms_tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         bite_o
);
  logic [W-1:0] cnt_q;
  logic         bite_q;
  logic         step;

  assign step    = run_i && ms_tick_i && (cnt_q != '0) && !load_i;
  assign count_o = cnt_q;
  assign bite_o  = bite_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= step && (cnt_q == W'(1));
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10: pulse only at zero and only from a running watchdog
  a_r10_bite_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |-> (count_o == '0));
  a_r10_bite_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bite_o |-> $past(run_i));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32,
  parameter int TICKS_PER_MS  = 4,
  parameter int COPY_TICKS    = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_tick_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        alarm_irq_o,
  output logic        ms_irq_o,
  output logic        wdog_rst_o
);
  localparam int SW = $clog2(NUM_SLOT);

  logic [3:0] page;
  wr_op_e     op;
  assign page = bus_addr_i[7:4];
  assign op   = wr_op_e'(bus_addr_i[3:2]);

  logic sec_tick, ms_tick, copy_v;
  logic [SW-1:0] copy_slot;

  logic alen_q, msen_q, wden_q, pend_q, wake_q;
  logic [31:0] ctrl_rd, ctrl_nx;
  logic [31:0] sh_p [NUM_PST];
  logic [31:0] live_p [NUM_PST];
  logic [31:0] sh_alarm, live_alarm, sh_secs, live_sec, wdog_cnt;
  logic [NUM_SLOT-1:0] stale_q, stale_hit;
  logic wr_ctrl, clr_pend, clr_wake, alarm_match;

  rtc_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC), .TICKS_PER_MS(TICKS_PER_MS)) u_tb (
    .clk_i, .rst_ni, .slow_tick_i, .sec_tick_o(sec_tick), .ms_tick_o(ms_tick));

  rtc_copy_seq #(.NUM_SLOT(NUM_SLOT), .COPY_TICKS(COPY_TICKS)) u_seq (
    .clk_i, .rst_ni, .slow_tick_i, .stale_i(stale_q), .copy_o(copy_v), .slot_o(copy_slot));

  rtc_wdog #(.W(32)) u_wdog (
    .clk_i, .rst_ni, .ms_tick_i(ms_tick),
    .run_i(wden_q && live_p[1][PB_WDOG_ARM]),
    .load_i(bus_we_i && page == PG_WDOG), .load_val_i(bus_wdata_i),
    .count_o(wdog_cnt), .bite_o(wdog_rst_o));

  // control word
  assign ctrl_rd  = {27'b0, wden_q, 1'b0, pend_q, msen_q, alen_q};
  assign ctrl_nx  = merge_write(ctrl_rd, bus_wdata_i, op);
  assign wr_ctrl  = bus_we_i && page == PG_CTRL;
  assign clr_pend = wr_ctrl && op == OP_CLEAR && bus_wdata_i[CB_PEND];
  assign clr_wake = bus_we_i && page == PG_PST0 && op == OP_CLEAR && bus_wdata_i[PB_WAKE_FLG];
  assign alarm_match = live_p[0][PB_ALRM_EN] && (live_sec == live_alarm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alen_q <= 1'b0;
      msen_q <= 1'b0;
      wden_q <= 1'b0;
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        alen_q <= ctrl_nx[CB_ALRM_IE];
        msen_q <= ctrl_nx[CB_MS_IE];
        wden_q <= ctrl_nx[CB_WDOG_EN];
      end
      // a match in the same cycle outranks the clear
      pend_q <= alarm_match | (pend_q & ~clr_pend);
      wake_q <= (alarm_match & live_p[0][PB_WAKE_EN]) | (wake_q & ~clr_wake);
    end
  end

  // write hits on shadowed registers
  for (genvar g = 0; g < NUM_PST; g++) begin : g_hit
    assign stale_hit[g] = bus_we_i && page == 4'(PG_PST0 + g);
  end
  assign stale_hit[SLOT_ALRM] = bus_we_i && page == PG_ALRM;
  assign stale_hit[SLOT_SECS] = bus_we_i && page == PG_SECS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PST; i++) begin
        sh_p[i]   <= '0;
        live_p[i] <= '0;
      end
      sh_alarm   <= '0;
      live_alarm <= '0;
      sh_secs    <= '0;
      live_sec   <= '0;
      stale_q    <= '0;
    end else begin
      for (int i = 0; i < NUM_PST; i++) begin
        if (stale_hit[i]) sh_p[i] <= merge_write(sh_p[i], bus_wdata_i, op);
        if (copy_v && copy_slot == SW'(i)) live_p[i] <= sh_p[i];
      end
      if (stale_hit[SLOT_ALRM]) sh_alarm <= bus_wdata_i;
      if (stale_hit[SLOT_SECS]) sh_secs  <= bus_wdata_i;
      if (copy_v && copy_slot == SW'(SLOT_ALRM)) live_alarm <= sh_alarm;
      if (copy_v && copy_slot == SW'(SLOT_SECS)) live_sec <= sh_secs;
      else if (sec_tick)                         live_sec <= live_sec + 1'b1;
      // a new write keeps the flag up even if its copy completes now
      for (int i = 0; i < NUM_SLOT; i++)
        stale_q[i] <= stale_hit[i] | (stale_q[i] & ~(copy_v && copy_slot == SW'(i)));
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (page)
      PG_CTRL: bus_rdata_o = ctrl_rd;
      PG_STAT: bus_rdata_o = {1'b1, 7'b0, stale_q, 16'b0};
      PG_SECS: bus_rdata_o = live_sec;
      PG_ALRM: bus_rdata_o = sh_alarm;
      PG_WDOG: bus_rdata_o = wdog_cnt;
      default: begin
        for (int i = 0; i < NUM_PST; i++)
          if (page == 4'(PG_PST0 + i)) bus_rdata_o = sh_p[i];
        if (page == PG_PST0) bus_rdata_o[PB_WAKE_FLG] = sh_p[0][PB_WAKE_FLG] | wake_q;
      end
    endcase
  end

  assign alarm_irq_o = pend_q & alen_q;
  assign ms_irq_o    = ms_tick & msen_q;

  logic [31:0] unused_live;
  logic        unused_misc;
  always_comb begin
    unused_live = '0;
    for (int i = 0; i < NUM_PST; i++) unused_live = unused_live ^ live_p[i];
  end
  assign unused_misc = ^{bus_addr_i[1:0], ctrl_nx};

  // R4: flags drop at most one per cycle
  a_r4_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(stale_q) & ~stale_q) <= 1);
  // R3: a write leaves its flag raised
  a_r3_alarm_stale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_hit[SLOT_ALRM] |=> stale_q[SLOT_ALRM]);
  // R5: seconds moves only by one step or by a copy
  a_r5_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(live_sec) |-> (live_sec == $past(live_sec) + 32'd1) ||
                           $past(copy_v && copy_slot == SW'(SLOT_SECS)));
  // R6: a match raises pending
  a_r6_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_match |=> pend_q);
  // R7: pending drops only after a clear-bits write
  a_r7_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(clr_pend));
  // R8: wake flag drops only after its clear
  a_r8_wake_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_q) |-> $past(clr_wake));
endmodule

// File: tb/sim_rtc_shadow.sv
module sim_rtc_shadow;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, msirq, wdrst;

  int n_chk = 0, n_fail = 0;
  int ms_pulses = 0, bites = 0;

  always #5 clk = ~clk;

  rtc_shadow u0 (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .alarm_irq_o(irq), .ms_irq_o(msirq), .wdog_rst_o(wdrst));

  // slow strobe: one cycle in four
  initial begin
    wait (rst_n);
    forever begin
      repeat (3) @(posedge clk);
      #2 slow_tick = 1'b1;
      @(posedge clk);
      #2 slow_tick = 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(int n);
    ms_pulses = 0; bites = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msirq) ms_pulses++;
      if (wdrst) bites++;
    end
  endtask

  task automatic wait_clean(output int clks);
    logic [31:0] s;
    clks = 0;
    for (int i = 0; i < 400; i++) begin
      rd(8'h10, s);
      if (s[23:16] == 8'h00) break;
      @(negedge clk);
      clks++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h10, d); chk("R1 status", d, 32'h8000_0000);
    rd(8'h30, d); chk("R1 seconds", d, 32'h0);
    chk("R1 outputs", {29'b0, irq, msirq, wdrst}, 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    int c;
    wr(8'h00, 32'h17); rd(8'h00, d); chk("R2 plain ctrl", d, 32'h13);
    wr(8'h08, 32'h12); rd(8'h00, d); chk("R2 clear ctrl", d, 32'h01);
    wr(8'h04, 32'h10); rd(8'h00, d); chk("R2 set ctrl", d, 32'h11);
    wr(8'h00, 32'h00); rd(8'h00, d); chk("R2 plain zero", d, 32'h0);
    wr(8'h80, 32'hA0);
    wr(8'h84, 32'h05); rd(8'h80, d); chk("R2 set pst2", d, 32'hA5);
    wr(8'h88, 32'h81); rd(8'h80, d); chk("R2 clear pst2", d, 32'h24);
    wait_clean(c);
  endtask

  task automatic t_stale;
    logic [31:0] d;
    int c;
    wr(8'h40, 32'h7);
    rd(8'h10, d); chk("R3 alarm stale bit22", d, 32'h8040_0000);
    wait_clean(c);
    rd(8'h10, d); chk("R3 stale cleared", d, 32'h8000_0000);
  endtask

  task automatic t_order;
    logic [31:0] d;
    logic [7:0] s;
    int bad = 0, clks = 0;
    wr(8'h60, 32'h0);
    wr(8'h70, 32'h0);
    for (int k = 2; k < 6; k++) wr(8'(8'h60 + 16 * k), 32'(k));
    wr(8'h40, 32'h7);
    wr(8'h30, 32'd1000);
    for (int i = 0; i < 400; i++) begin
      rd(8'h10, d);
      s = d[23:16];
      if (s == 8'h00) break;
      if ((9'(s) + 9'(s & (~s + 8'h01))) != 9'h100) bad++;
      @(negedge clk);
      clks++;
    end
    chk("R4 drain from low end", 32'(bad), 32'h0);
    chk("R4 within 12 slow ticks", 32'(clks <= 48), 32'h1);
    rd(8'h30, d); chk("R5 seconds copied", d, 32'd1000);
    rd(8'h40, d); chk("R4 alarm shadow", d, 32'd7);
  endtask

  task automatic t_secs;
    logic [31:0] v, d;
    rd(8'h30, v);
    run(128); rd(8'h30, d); chk("R5 one second", d, v + 1);
    run(128); rd(8'h30, d); chk("R5 two seconds", d, v + 2);
  endtask

  task automatic t_ms;
    wr(8'h04, 32'h2);
    run(160); chk("R9 ten ms pulses", 32'(ms_pulses), 32'd10);
    wr(8'h08, 32'h2);
    run(160); chk("R9 masked", 32'(ms_pulses), 32'd0);
  endtask

  task automatic t_wdog;
    logic [31:0] d;
    int c;
    wr(8'h74, 32'h8000_0000);
    wait_clean(c);
    wr(8'h50, 32'd3);
    wr(8'h04, 32'h10);
    run(120); chk("R10 one bite", 32'(bites), 32'd1);
    rd(8'h50, d); chk("R10 count at zero", d, 32'd0);
    run(60); chk("R10 zero no bite", 32'(bites), 32'd0);
    wr(8'h08, 32'h10);
    wr(8'h50, 32'd5);
    run(100); rd(8'h50, d); chk("R10 disabled holds", d, 32'd5);
    chk("R10 disabled no bite", 32'(bites), 32'd0);
    wr(8'h04, 32'h10);
    run(120); chk("R10 re-enabled bite", 32'(bites), 32'd1);
    wr(8'h08, 32'h10);
  endtask

  task automatic t_alarm;
    logic [31:0] d;
    int c;
    wr(8'h40, 32'd50);
    wr(8'h30, 32'd45);
    wait_clean(c);
    wr(8'h64, 32'h6);
    wr(8'h04, 32'h1);
    wait_clean(c);
    rd(8'h00, d); chk("R6 no match yet", d & 32'h4, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 1000; i++) begin
      rd(8'h30, d);
      if (d == 32'd50) break;
      @(negedge clk);
    end
    run(2);
    rd(8'h00, d); chk("R6 pending set", d & 32'h4, 32'h4);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    rd(8'h60, d); chk("R8 wake flag", d & 32'h80, 32'h80);
    wr(8'h08, 32'h1);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h4);
    rd(8'h00, d); chk("R7 match beats clear", d & 32'h4, 32'h4);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R7 plain write ignored", d & 32'h4, 32'h4);
    wr(8'h68, 32'h4);
    wait_clean(c);
    wr(8'h08, 32'h4);
    rd(8'h00, d); chk("R7 cleared", d & 32'h4, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    wr(8'h68, 32'h80);
    rd(8'h60, d); chk("R8 wake cleared", d, 32'h2);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_alias;
    t_stale;
    t_order;
    t_secs;
    t_ms;
    t_wdog;
    t_alarm;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule